// File: doc/BRIEF.md
# SMBus Target Address Match and Event Controller

This block is the target-side sequencing logic of an SMBus controller. A bus front end, outside this block, turns line activity into byte-level events: an address byte, a byte written by the master, a request for the next byte the master wants to read, and a stop condition. The block decides whether to acknowledge each one. It matches address bytes against four programmable 7-bit target addresses. It stores written bytes in a receive queue that software drains. It also paces read responses. When the master reads, the block holds the bus clock stretched until software supplies the byte and arms the transfer. The stretch is bounded, so a software stall ends in a distinct timeout status instead of a hung bus.

Software uses eight word registers, selected by a 3-bit index. Index 0 holds the addresses and index 1 holds timing. Index 2 is queue control and index 3 is command/status. Index 4 enables interrupts and index 5 holds interrupt status. Index 6 is the transmit byte and index 7 is the receive queue head. Each interrupt source is a sticky status bit that is cleared by writing 1. The interrupt output is the OR of every status bit whose enable is set.

Top module: `smb_tgt`

## Requirements
- R1: After reset, all bus and interrupt outputs are low. Busy (command bit 31) and status (bits 25:23) read 0. The stretch limit (timing bits 30:24) reads 25. A receive read returns 0.
- R2: Slot k of the address register holds an address at bits 8k+6:8k and its enable at bit 8k+7. An address byte whose bits 7:1 equal the address of an enabled slot is acknowledged (bus_ack high in the cycle after the event). A byte that matches only a disabled slot, or no slot, is not acknowledged.
- R3: After a matching address with bit 0 = 0, the address byte is queued with tag 1 and each following written byte is queued with tag 2 and acknowledged. Reading index 7 returns the oldest entry (tag at bits 31:30, byte at 7:0) and removes it. An empty queue reads tag 0.
- R4: Written bytes that arrive while the block is not addressed for a write are neither acknowledged nor queued.
- R5: A byte for a full queue is not acknowledged and is dropped, and interrupt status bit 26 is set.
- R6: Every queued byte sets status bit 24. A push that brings the count to at least a nonzero threshold (index 2 bits 13:8) sets bit 25. The count reads at index 2 bits 22:16. Writing 1 to index 2 bit 31 empties the queue.
- R7: A matching address with bit 0 = 1 is acknowledged, sets status bit 21 and asserts bus_stretch. Stretch holds until a byte has been written to index 6 and busy has been set by writing bit 31 of index 3. The byte then appears on bus_tx_data with a one-cycle bus_tx_valid, and stretch drops.
- R8: A next-byte request with no byte pending sets status bit 22 and stretches again. A byte already pending while busy is sent at once.
- R9: Stretch lasting the limit times PRESCALE cycles ends. Stretch is released, busy clears, status reads 5 and status bit 23 is set.
- R10: A stop while addressed clears busy and sets status bit 23. A stop while idle changes nothing.
- R11: irq is high exactly while some interrupt status bit and its enable (index 4, same positions 26:21) are both set. Writing 1s to index 5 clears those bits.
- R12: Writing 1 to index 2 bit 30 discards a pending transmit byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | Bus event present this cycle |
| ev_kind | input | 2 | 0 address byte, 1 written byte, 2 next read byte wanted, 3 stop |
| ev_byte | input | 8 | Byte carried by address and write events |
| bus_ack | output | 1 | Acknowledge for the previous cycle's event |
| bus_stretch | output | 1 | Hold the bus clock low |
| bus_tx_valid | output | 1 | One-cycle strobe, byte for the master |
| bus_tx_data | output | 8 | Byte for the master |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe, data next cycle |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with a four-entry receive queue and a prescale of two. The small queue lets a short write burst reach the full condition and show the dropped, unacknowledged byte and the threshold flag. The small prescale, combined with a programmed stretch limit of six, makes the clock-stretch timeout reachable within a few dozen cycles. This exposes its exact release cycle against the R9 window.

// File: rtl/smb_tgt_pkg.sv
package smb_tgt_pkg;

    typedef enum logic [1:0] {
        EV_ADDR  = 2'd0,
        EV_WDATA = 2'd1,
        EV_RNEXT = 2'd2,
        EV_STOP  = 2'd3
    } ev_kind_e;

    typedef enum logic [1:0] {
        M_IDLE    = 2'd0,
        M_WRITE   = 2'd1,
        M_RD_WAIT = 2'd2,
        M_RD_SEND = 2'd3
    } mode_e;

    // register word indices
    localparam logic [2:0] RA_ADDR = 3'd0;
    localparam logic [2:0] RA_TIM  = 3'd1;
    localparam logic [2:0] RA_FCTL = 3'd2;
    localparam logic [2:0] RA_CMD  = 3'd3;
    localparam logic [2:0] RA_IEN  = 3'd4;
    localparam logic [2:0] RA_IST  = 3'd5;
    localparam logic [2:0] RA_TXD  = 3'd6;
    localparam logic [2:0] RA_RXD  = 3'd7;

    localparam int NSLOT   = 4;
    localparam int SLOT_W  = 8;
    localparam int LIM_W   = 7;
    localparam int THLD_W  = 6;
    localparam int IRQ_N   = 6;
    localparam int IRQ_LSB = 21;
    localparam logic [LIM_W-1:0] LIM_RESET = 7'd25;

    // interrupt vector positions (register bit = IRQ_LSB + index)
    localparam int IQ_RDREQ = 0;
    localparam int IQ_UNDER = 1;
    localparam int IQ_SBUSY = 2;
    localparam int IQ_RXEV  = 3;
    localparam int IQ_THLD  = 4;
    localparam int IQ_FULL  = 5;

    localparam logic [1:0] RXT_START = 2'd1;
    localparam logic [1:0] RXT_DATA  = 2'd2;
    localparam logic [2:0] ST_OK      = 3'd0;
    localparam logic [2:0] ST_TIMEOUT = 3'd5;
    localparam int RX_ENTRY_W = 10;

    typedef struct packed {
        mode_e             mode;
        logic              busy;
        logic [2:0]        status;
        logic [LIM_W-1:0]  lim;
        logic [31:0]       addr_cfg;
        logic [IRQ_N-1:0]  irq_en;
        logic [IRQ_N-1:0]  irq_st;
        logic [THLD_W-1:0] thld;
        logic [7:0]        tx_data;
        logic              tx_full;
        logic              ack;
        logic              tx_valid;
        logic [7:0]        tx_out;
        logic [31:0]       rdata;
    } tgt_state_t;

endpackage

// File: rtl/smb_tgt_match.sv
module smb_tgt_match
    import smb_tgt_pkg::*;
(
    input  logic [31:0] cfg,
    input  logic [6:0]  addr7,
    output logic        hit
);
    logic [NSLOT-1:0] slot_hit;

    for (genvar k = 0; k < NSLOT; k++) begin : g_slot
        assign slot_hit[k] = cfg[k*SLOT_W + 7] && (cfg[k*SLOT_W +: 7] == addr7);
    end

    assign hit = |slot_hit;
endmodule

// File: rtl/smb_tgt_fifo.sv
module smb_tgt_fifo #(
    parameter int DEPTH = 64,
    parameter int W     = 10
)(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [W-1:0]               push_data,
    input  logic                       pop,
    input  logic                       flush,
    output logic [W-1:0]               head,
    output logic                       empty,
    output logic                       full,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          do_push, do_pop;

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == CW'(DEPTH));
    assign count   = cnt_q;
    assign head    = mem[rp_q];
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        wp_d  = wp_q;
        rp_d  = rp_q;
        cnt_d = cnt_q;
        if (flush) begin
            wp_d  = '0;
            rp_d  = '0;
            cnt_d = '0;
        end else begin
            if (do_push) wp_d = bump(wp_q);
            if (do_pop)  rp_d = bump(rp_q);
            if (do_push && !do_pop) cnt_d = cnt_q + 1'b1;
            if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            wp_q  <= wp_d;
            rp_q  <= rp_d;
            cnt_q <= cnt_d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wp_q] <= push_data;
    end
endmodule

// File: rtl/smb_tgt_stretch_timer.sv
module smb_tgt_stretch_timer #(
    parameter int PRESCALE = 16,
    parameter int LIM_W    = 7
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [LIM_W-1:0] limit,
    output logic             expired
);
    localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

    logic [PRE_W-1:0] pre_q, pre_d;
    logic [LIM_W-1:0] cnt_q, cnt_d;

    always_comb begin
        pre_d = pre_q;
        cnt_d = cnt_q;
        if (!run) begin
            pre_d = '0;
            cnt_d = '0;
        end else if (cnt_q != limit) begin
            if (pre_q == PRE_W'(PRESCALE-1)) begin
                pre_d = '0;
                cnt_d = cnt_q + 1'b1;
            end else begin
                pre_d = pre_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
            cnt_q <= '0;
        end else begin
            pre_q <= pre_d;
            cnt_q <= cnt_d;
        end
    end

    assign expired = run && (cnt_q == limit);
endmodule

// File: rtl/smb_tgt.sv
module smb_tgt
    import smb_tgt_pkg::*;
#(
    parameter int FIFO_DEPTH = 64,
    parameter int PRESCALE   = 16
)(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ev_valid,
    input  logic [1:0]  ev_kind,
    input  logic [7:0]  ev_byte,
    output logic        bus_ack,
    output logic        bus_stretch,
    output logic        bus_tx_valid,
    output logic [7:0]  bus_tx_data,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq
);
    localparam int CNT_W = $clog2(FIFO_DEPTH+1);

    tgt_state_t st_q, st_d;

    logic                  addr_hit;
    logic                  push, pop, flush;
    logic [RX_ENTRY_W-1:0] push_data, fifo_head;
    logic                  fifo_empty, fifo_full;
    logic [CNT_W-1:0]      fifo_cnt;
    logic                  timer_run, expired;
    logic [IRQ_N-1:0]      irq_set, irq_clr;
    logic [7:0]            cnt_after;
    logic [6:0]            cnt7;
    ev_kind_e              ev_e;

    // observation points for the bound checker
    logic                  busy_w;
    logic [2:0]            status_w;
    logic [LIM_W-1:0]      lim_w;
    logic                  rx_full_w;

    assign ev_e = ev_kind_e'(ev_kind);
    assign cnt7 = 7'(fifo_cnt);

    smb_tgt_match u_match (
        .cfg   (st_q.addr_cfg),
        .addr7 (ev_byte[7:1]),
        .hit   (addr_hit)
    );

    smb_tgt_fifo #(.DEPTH(FIFO_DEPTH), .W(RX_ENTRY_W)) u_rxq (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (push_data),
        .pop       (pop),
        .flush     (flush),
        .head      (fifo_head),
        .empty     (fifo_empty),
        .full      (fifo_full),
        .count     (fifo_cnt)
    );

    assign timer_run = (st_q.mode == M_RD_WAIT);

    smb_tgt_stretch_timer #(.PRESCALE(PRESCALE), .LIM_W(LIM_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (timer_run),
        .limit   (st_q.lim),
        .expired (expired)
    );

    always_comb begin
        st_d          = st_q;
        st_d.ack      = 1'b0;
        st_d.tx_valid = 1'b0;
        irq_set       = '0;
        irq_clr       = '0;
        push          = 1'b0;
        push_data     = '0;
        pop           = 1'b0;
        flush         = 1'b0;
        cnt_after     = 8'(fifo_cnt) + 8'd1;

        // ---- bus events ----
        if (ev_valid) begin
            unique case (ev_e)
                EV_ADDR: begin
                    if (!addr_hit) begin
                        st_d.mode = M_IDLE;
                    end else if (ev_byte[0]) begin
                        st_d.ack  = 1'b1;
                        st_d.mode = M_RD_WAIT;
                        irq_set[IQ_RDREQ] = 1'b1;
                    end else if (fifo_full) begin
                        st_d.mode = M_IDLE;
                        irq_set[IQ_FULL] = 1'b1;
                    end else begin
                        st_d.ack  = 1'b1;
                        st_d.mode = M_WRITE;
                        push      = 1'b1;
                        push_data = {RXT_START, ev_byte};
                    end
                end
                EV_WDATA: begin
                    if (st_q.mode == M_WRITE) begin
                        if (fifo_full) begin
                            irq_set[IQ_FULL] = 1'b1;
                        end else begin
                            st_d.ack  = 1'b1;
                            push      = 1'b1;
                            push_data = {RXT_DATA, ev_byte};
                        end
                    end
                end
                EV_RNEXT: begin
                    if (st_q.mode == M_RD_SEND) begin
                        if (st_q.tx_full && st_q.busy) begin
                            st_d.tx_valid = 1'b1;
                            st_d.tx_out   = st_q.tx_data;
                            st_d.tx_full  = 1'b0;
                        end else begin
                            st_d.mode = M_RD_WAIT;
                            irq_set[IQ_UNDER] = 1'b1;
                        end
                    end
                end
                EV_STOP: begin
                    if (st_q.mode != M_IDLE) begin
                        st_d.mode = M_IDLE;
                        st_d.busy = 1'b0;
                        irq_set[IQ_SBUSY] = 1'b1;
                    end
                end
                default: ;
            endcase
        end

        // ---- paced read: release on supplied byte or on timeout ----
        if (st_q.mode == M_RD_WAIT && st_d.mode == M_RD_WAIT) begin
            if (st_q.tx_full && st_q.busy) begin
                st_d.tx_valid = 1'b1;
                st_d.tx_out   = st_q.tx_data;
                st_d.tx_full  = 1'b0;
                st_d.mode     = M_RD_SEND;
            end else if (expired) begin
                st_d.mode   = M_IDLE;
                st_d.busy   = 1'b0;
                st_d.status = ST_TIMEOUT;
                irq_set[IQ_SBUSY] = 1'b1;
            end
        end

        if (push) begin
            irq_set[IQ_RXEV] = 1'b1;
            if (st_q.thld != '0 && cnt_after >= {2'b00, st_q.thld})
                irq_set[IQ_THLD] = 1'b1;
        end

        // ---- register writes (after bus logic so a new TX byte wins) ----
        if (reg_wr) begin
            unique case (reg_addr)
                RA_ADDR: st_d.addr_cfg = reg_wdata;
                RA_TIM:  st_d.lim      = reg_wdata[30:24];
                RA_FCTL: begin
                    st_d.thld = reg_wdata[13:8];
                    flush     = reg_wdata[31];
                    if (reg_wdata[30]) st_d.tx_full = 1'b0;
                end
                RA_CMD: begin
                    if (reg_wdata[31]) begin
                        st_d.busy   = 1'b1;
                        st_d.status = ST_OK;
                    end
                end
                RA_IEN:  st_d.irq_en = reg_wdata[IRQ_LSB +: IRQ_N];
                RA_IST:  irq_clr     = reg_wdata[IRQ_LSB +: IRQ_N];
                RA_TXD: begin
                    st_d.tx_data = reg_wdata[7:0];
                    st_d.tx_full = 1'b1;
                end
                default: ;
            endcase
        end

        st_d.irq_st = (st_q.irq_st & ~irq_clr) | irq_set;

        // ---- register reads ----
        if (reg_rd) begin
            unique case (reg_addr)
                RA_ADDR: st_d.rdata = st_q.addr_cfg;
                RA_TIM:  st_d.rdata = {1'b0, st_q.lim, 24'd0};
                RA_FCTL: st_d.rdata = {9'd0, cnt7, 2'd0, st_q.thld, 8'd0};
                RA_CMD:  st_d.rdata = {st_q.busy, 5'd0, st_q.status, 23'd0};
                RA_IEN:  st_d.rdata = {5'd0, st_q.irq_en, 21'd0};
                RA_IST:  st_d.rdata = {5'd0, st_q.irq_st, 21'd0};
                RA_TXD:  st_d.rdata = {24'd0, st_q.tx_data};
                RA_RXD: begin
                    if (fifo_empty) begin
                        st_d.rdata = '0;
                    end else begin
                        pop        = 1'b1;
                        st_d.rdata = {fifo_head[9:8], 22'd0, fifo_head[7:0]};
                    end
                end
                default: st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.lim <= LIM_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_ack      = st_q.ack;
    assign bus_stretch  = (st_q.mode == M_RD_WAIT);
    assign bus_tx_valid = st_q.tx_valid;
    assign bus_tx_data  = st_q.tx_out;
    assign reg_rdata    = st_q.rdata;
    assign irq          = |(st_q.irq_st & st_q.irq_en);

    assign busy_w    = st_q.busy;
    assign status_w  = st_q.status;
    assign lim_w     = st_q.lim;
    assign rx_full_w = fifo_full;
endmodule

// File: rtl/smb_tgt_chk.sv
module smb_tgt_chk #(
    parameter int PRESCALE = 16
)(
    input logic       clk,
    input logic       rst_n,
    input logic       ev_valid,
    input logic [1:0] ev_kind,
    input logic       bus_ack,
    input logic       bus_stretch,
    input logic       bus_tx_valid,
    input logic       busy,
    input logic [2:0] status,
    input logic [6:0] lim,
    input logic       rx_full
);
    logic [31:0] run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           run_len <= '0;
        else if (bus_stretch) run_len <= run_len + 1;
        else                  run_len <= '0;
    end

    // R2: an acknowledge only ever answers an event of the cycle before
    p_ack_follows_event_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |-> $past(ev_valid));

    // R5: a written byte meeting a full queue is refused
    p_full_refuses_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_kind == 2'd1 && rx_full) |=> !bus_ack);

    // R7: a byte handed to the bus coincides with the clock being released
    p_tx_releases_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_tx_valid |-> !bus_stretch);

    // R9: no stretch outlives the programmed window
    p_stretch_bounded_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_stretch |-> (run_len <= 32'(lim) * 32'(PRESCALE) + 32'd2));

    // R9: the timeout code is never reported alongside a busy transfer
    p_timeout_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 3'd5) |-> !busy);

    // R10: a stop leaves no stretch and sends no byte
    p_stop_releases_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_kind == 2'd3) |=> (!bus_stretch && !bus_tx_valid));
endmodule

bind smb_tgt smb_tgt_chk #(.PRESCALE(PRESCALE)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ev_valid     (ev_valid),
    .ev_kind      (ev_kind),
    .bus_ack      (bus_ack),
    .bus_stretch  (bus_stretch),
    .bus_tx_valid (bus_tx_valid),
    .busy         (busy_w),
    .status       (status_w),
    .lim          (lim_w),
    .rx_full      (rx_full_w)
);

// File: tb/smb_tgt_test.sv
`timescale 1ns/1ps
module smb_tgt_test;
    localparam int DEPTH = 4;
    localparam int PRE   = 2;
    localparam int WD_CYCLES = 100000;

    localparam logic [1:0] K_ADDR = 2'd0, K_WR = 2'd1, K_NEXT = 2'd2, K_STOP = 2'd3;
    localparam logic [2:0] I_ADDR = 3'd0, I_TIM = 3'd1, I_FCTL = 3'd2, I_CMD = 3'd3,
                           I_IEN = 3'd4, I_IST = 3'd5, I_TXD = 3'd6, I_RXD = 3'd7;
    localparam logic [31:0] ALL_IRQ = 32'h07E0_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_valid = 1'b0;
    logic [1:0]  ev_kind = '0;
    logic [7:0]  ev_byte = '0;
    logic        bus_ack, bus_stretch, bus_tx_valid, irq;
    logic [7:0]  bus_tx_data;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    logic [7:0] exp_q [$];

    always #2.5 clk = ~clk;

    smb_tgt #(.FIFO_DEPTH(DEPTH), .PRESCALE(PRE)) uut (
        .clk(clk), .rst_n(rst_n),
        .ev_valid(ev_valid), .ev_kind(ev_kind), .ev_byte(ev_byte),
        .bus_ack(bus_ack), .bus_stretch(bus_stretch),
        .bus_tx_valid(bus_tx_valid), .bus_tx_data(bus_tx_data),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_ev(input logic [1:0] k, input logic [7:0] b);
        @(negedge clk);
        ev_valid = 1'b1; ev_kind = k; ev_byte = b;
        @(negedge clk);
        ev_valid = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // scoreboard driver side: record a byte the master must receive
    task automatic expect_tx(input logic [7:0] b);
        exp_q.push_back(b);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // scoreboard monitor side
    always @(negedge clk) begin
        if (rst_n && bus_tx_valid) begin
            if (exp_q.size() == 0) begin
                chk("R7/R8 unexpected byte", {24'd0, bus_tx_data}, 32'hFFFF_FFFF);
            end else begin
                chk("R7/R8 byte to master", {24'd0, bus_tx_data}, {24'd0, exp_q.pop_front()});
            end
        end
    end

    initial begin
        for (int i = 0; i < WD_CYCLES; i++) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        idle(4);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        chk("R1 ack", {31'd0, bus_ack}, 32'd0);
        chk("R1 stretch", {31'd0, bus_stretch}, 32'd0);
        chk("R1 tx_valid", {31'd0, bus_tx_valid}, 32'd0);
        chk("R1 irq", {31'd0, irq}, 32'd0);
        rd(I_TIM, v);  chk("R1 limit", {25'd0, v[30:24]}, 32'd25);
        rd(I_CMD, v);  chk("R1 cmd", v, 32'd0);
        rd(I_RXD, v);  chk("R1 rx empty", v, 32'd0);

        wr(I_ADDR, 32'hBA55_00A1);  // slot0 0x21 on, slot2 0x55 off, slot3 0x3A on
        wr(I_IEN, ALL_IRQ);

        // R2 disabled slot, R4 stray data
        bus_ev(K_ADDR, 8'hAA); chk("R2 disabled slot nack", {31'd0, bus_ack}, 32'd0);
        bus_ev(K_WR, 8'h11);   chk("R4 stray byte nack", {31'd0, bus_ack}, 32'd0);
        rd(I_RXD, v);          chk("R4 nothing queued", v, 32'd0);

        // R2 / R3 write transfer to slot 3
        bus_ev(K_ADDR, 8'h74); chk("R2 slot3 ack", {31'd0, bus_ack}, 32'd1);
        bus_ev(K_WR, 8'hC3);   chk("R3 data ack", {31'd0, bus_ack}, 32'd1);
        bus_ev(K_WR, 8'h5E);   chk("R3 data ack", {31'd0, bus_ack}, 32'd1);
        bus_ev(K_STOP, 8'h00);
        rd(I_IST, v);          chk("R6 R10 rx event and stop bits", v, 32'h0180_0000);
        chk("R11 irq high", {31'd0, irq}, 32'd1);
        rd(I_RXD, v);          chk("R3 start entry", v, 32'h4000_0074);
        rd(I_RXD, v);          chk("R3 data entry 1", v, 32'h8000_00C3);
        rd(I_RXD, v);          chk("R3 data entry 2", v, 32'h8000_005E);
        rd(I_RXD, v);          chk("R3 drained", v, 32'd0);

        // R11 enable gating and write-1-to-clear
        wr(I_IEN, 32'd0);      chk("R11 masked", {31'd0, irq}, 32'd0);
        wr(I_IEN, ALL_IRQ);    chk("R11 unmasked", {31'd0, irq}, 32'd1);
        wr(I_IST, ALL_IRQ);    chk("R11 cleared", {31'd0, irq}, 32'd0);
        rd(I_IST, v);          chk("R11 status zero", v, 32'd0);

        // R5 / R6 fill the queue to overflow, threshold 3
        wr(I_FCTL, 32'h0000_0300);
        bus_ev(K_ADDR, 8'h42); chk("R2 slot0 ack", {31'd0, bus_ack}, 32'd1);
        bus_ev(K_WR, 8'h01);
        bus_ev(K_WR, 8'h02);
        bus_ev(K_WR, 8'h03);   chk("R5 last fits", {31'd0, bus_ack}, 32'd1);
        bus_ev(K_WR, 8'h04);   chk("R5 overflow nack", {31'd0, bus_ack}, 32'd0);
        rd(I_FCTL, v);         chk("R6 count", {25'd0, v[22:16]}, 32'd4);
        rd(I_IST, v);          chk("R5 R6 full thld rx bits", v, 32'h0700_0000);
        wr(I_FCTL, 32'h8000_0000);
        rd(I_RXD, v);          chk("R6 flushed", v, 32'd0);
        rd(I_FCTL, v);         chk("R6 count after flush", {25'd0, v[22:16]}, 32'd0);
        bus_ev(K_STOP, 8'h00);
        wr(I_IST, ALL_IRQ);

        // R7 paced read
        bus_ev(K_ADDR, 8'h43); chk("R7 read ack", {31'd0, bus_ack}, 32'd1);
        chk("R7 stretch", {31'd0, bus_stretch}, 32'd1);
        idle(5);
        wr(I_TXD, 32'h0000_009C);
        idle(2);               chk("R7 holds without busy", {31'd0, bus_stretch}, 32'd1);
        expect_tx(8'h9C);
        wr(I_CMD, 32'h8000_0000);
        idle(1);               chk("R7 released", {31'd0, bus_stretch}, 32'd0);
        rd(I_CMD, v);          chk("R7 busy set", v, 32'h8000_0000);

        // R8 underrun then immediate send
        bus_ev(K_NEXT, 8'h00); chk("R8 stretch again", {31'd0, bus_stretch}, 32'd1);
        rd(I_IST, v);          chk("R7 R8 rdreq underrun bits", v, 32'h0060_0000);
        expect_tx(8'h3D);
        wr(I_TXD, 32'h0000_003D);
        idle(1);               chk("R8 released", {31'd0, bus_stretch}, 32'd0);
        expect_tx(8'h77);
        wr(I_TXD, 32'h0000_0077);
        bus_ev(K_NEXT, 8'h00); chk("R8 no stretch when ready", {31'd0, bus_stretch}, 32'd0);
        bus_ev(K_STOP, 8'h00);
        rd(I_CMD, v);          chk("R10 busy cleared ok", v, 32'd0);
        rd(I_IST, v);          chk("R10 stop bit", {31'd0, v[23]}, 32'd1);
        wr(I_IST, ALL_IRQ);

        // R12 TX flush discards pending byte
        bus_ev(K_ADDR, 8'h43);
        wr(I_TXD, 32'h0000_00EE);
        wr(I_FCTL, 32'h4000_0000);
        wr(I_CMD, 32'h8000_0000);
        idle(3);               chk("R12 still stretched", {31'd0, bus_stretch}, 32'd1);
        bus_ev(K_STOP, 8'h00); chk("R10 stop releases", {31'd0, bus_stretch}, 32'd0);
        wr(I_IST, ALL_IRQ);

        // R9 timeout, limit 6 -> 12 cycles of stretch
        wr(I_TIM, 32'h0600_0000);
        bus_ev(K_ADDR, 8'h43);
        idle(9);               chk("R9 before limit", {31'd0, bus_stretch}, 32'd1);
        idle(7);               chk("R9 after limit", {31'd0, bus_stretch}, 32'd0);
        rd(I_CMD, v);          chk("R9 timeout status", v, 32'h0280_0000);
        rd(I_IST, v);          chk("R9 busy-done bit", {31'd0, v[23]}, 32'd1);
        wr(I_IST, ALL_IRQ);

        // R10 stop while idle is ignored
        wr(I_CMD, 32'h8000_0000);
        bus_ev(K_STOP, 8'h00);
        rd(I_IST, v);          chk("R10 idle stop no bit", v, 32'd0);
        rd(I_CMD, v);          chk("R10 idle stop keeps busy", v, 32'h8000_0000);

        chk("R7 all bytes delivered", exp_q.size(), 32'd0);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule